// File: doc/BRIEF.md
# Dual-Mode Interrupt Pin Controller

This block drives a single active-low, open-drain interrupt pin. A configuration bit picks what the pin means. In general mode a bank of status bits collects event pulses. The pin is pulled low while any status bit whose enable is set is pending. It is released only after software clears those bits by writing ones. In suspend mode the pin does not follow the status bits. Instead it shows the hub's USB state as a live level: it is low when the hub is unconfigured, or when it is configured but suspended. It is released when the hub is configured and active.

The output `irq_pull` is the enable of the pin's pull-down driver. When it is 1 the pad drives low. When it is 0 the pad floats and an external pull-up holds the line high. The block never drives the line high.

Inside there are two parts. A status bank holds one write-one-to-clear bit per event source. A three-state machine chooses the pin level. Its states are `PIN_RELEASED`, `PIN_GEN_LOW` and `PIN_SUS_LOW`. On every clock edge the machine moves to the state that the current inputs call for:
- If `mode_susp` is 1 and the hub is unconfigured or suspended, it goes to `PIN_SUS_LOW`.
- If `mode_susp` is 1 and the hub is configured and active, it goes to `PIN_RELEASED`.
- If `mode_susp` is 0 and any enabled status bit is pending, it goes to `PIN_GEN_LOW`.
- In all other cases it goes to `PIN_RELEASED`.

Because of this, each transition happens on the first edge after its condition appears. `irq_pull` is 1 in both LOW states.

Top module: `irq_pin_ctrl`

## Requirements
- R1: `irq_pull` is the only output and is a pull-down enable: 1 means the pin is driven low, 0 means it is released. It is 1 exactly when the state machine is in `PIN_GEN_LOW` or `PIN_SUS_LOW`.
- R2: A 1 on bit i of `set_pulse` sets status bit i at the next clock edge. When a set and a clear of the same bit arrive in the same cycle, the set wins and the bit ends at 1.
- R3: Status bits are write-one-to-clear. When `clr_we` is 1, each bit of `clr_data` that is 1 clears the matching status bit at the next edge. Bits written as 0 are left unchanged.
- R4: With `mode_susp` = 0, `irq_pull` becomes 1 on the edge after some status bit i with `irq_en[i]` = 1 is set. That is two edges after the `set_pulse` cycle.
- R5: A status bit whose enable is 0 still latches but does not pull the pin. If its enable is raised later, the pin is pulled one edge after the change.
- R6: In general mode the pin stays low until every enabled pending bit has been cleared. It is released on the edge after the clearing edge.
- R7: With `mode_susp` = 1, one edge after any input change `irq_pull` equals (not `hub_configured`) or `hub_suspended`, whatever the status bits hold.
- R8: A change of `mode_susp` takes effect on the next edge. Status bits keep their values across mode changes.
- R9: While `rst_n` is 0, all status bits clear and the state machine returns to `PIN_RELEASED`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_pulse | input | NUM_SRC | One-cycle event pulses, one bit per status bit |
| clr_we | input | 1 | Write strobe for clearing status |
| clr_data | input | NUM_SRC | Write data; a 1 clears the matching status bit |
| irq_en | input | NUM_SRC | Enable mask for general mode |
| mode_susp | input | 1 | 0 = general interrupt, 1 = suspend indication |
| hub_configured | input | 1 | Hub has been configured |
| hub_suspended | input | 1 | Hub is in USB suspend |
| irq_pull | output | 1 | Pull-down enable for the open-drain pin |

## Verification
A set pulse or a clear write reaches the pin two edges later. The first edge updates the status bank and the second updates the state machine. A change to the enable mask, the mode bit or the hub flags reaches the pin after one edge. The bench drives inputs on the falling edge and samples on a later falling edge. It samples after exactly one edge as well, to confirm that set and clear pulses have not yet reached the pin. Mask, status and hub-state combinations are swept exhaustively over four sources.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
    typedef enum logic [1:0] {
        PIN_RELEASED = 2'd0,
        PIN_GEN_LOW  = 2'd1,
        PIN_SUS_LOW  = 2'd2
    } pin_state_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_pulse,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_data,
    output logic [NUM_SRC-1:0] status_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
            end else if (set_pulse[i]) begin
                // a set in the same cycle as a clear wins
                status_q[i] <= 1'b1;
            end else if (clr_we && clr_data[i]) begin
                status_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_pin_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_susp,
    input  logic               hub_configured,
    input  logic               hub_suspended,
    input  logic [NUM_SRC-1:0] status_q,
    input  logic [NUM_SRC-1:0] irq_en,
    output logic               irq_pull
);
    pin_state_e state_q, state_d;
    logic       pending;
    logic       hub_idle;

    assign pending  = |(status_q & irq_en);
    assign hub_idle = !hub_configured || hub_suspended;

    always_comb begin
        if (mode_susp) begin
            state_d = hub_idle ? PIN_SUS_LOW : PIN_RELEASED;
        end else begin
            state_d = pending ? PIN_GEN_LOW : PIN_RELEASED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_RELEASED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            PIN_RELEASED: irq_pull = 1'b0;
            PIN_GEN_LOW:  irq_pull = 1'b1;
            PIN_SUS_LOW:  irq_pull = 1'b1;
            default:      irq_pull = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_pulse,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_data,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               mode_susp,
    input  logic               hub_configured,
    input  logic               hub_suspended,
    output logic               irq_pull
);
    logic [NUM_SRC-1:0] status_q;

    irq_status_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (set_pulse),
        .clr_we    (clr_we),
        .clr_data  (clr_data),
        .status_q  (status_q)
    );

    irq_pin_fsm #(.NUM_SRC(NUM_SRC)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_susp      (mode_susp),
        .hub_configured (hub_configured),
        .hub_suspended  (hub_suspended),
        .status_q       (status_q),
        .irq_en         (irq_en),
        .irq_pull       (irq_pull)
    );
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk #(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] set_pulse,
    input logic               clr_we,
    input logic [NUM_SRC-1:0] clr_data,
    input logic [NUM_SRC-1:0] irq_en,
    input logic               mode_susp,
    input logic               hub_configured,
    input logic               hub_suspended,
    input logic [NUM_SRC-1:0] status_q,
    input logic               irq_pull
);
    a_r2_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pulse != '0) |=> ((status_q & $past(set_pulse)) == $past(set_pulse)));

    a_r3_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((status_q & $past(clr_data & ~set_pulse)) == '0));

    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pulse == '0) |=> ((status_q & ~$past(status_q)) == '0));

    a_r4_gen_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_susp && ((status_q & irq_en) != '0)) |=> irq_pull);

    a_r6_gen_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_susp && ((status_q & irq_en) == '0)) |=> !irq_pull);

    a_r7_sus_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_susp && (!hub_configured || hub_suspended)) |=> irq_pull);

    a_r7_sus_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_susp && hub_configured && !hub_suspended) |=> !irq_pull);
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .set_pulse      (set_pulse),
    .clr_we         (clr_we),
    .clr_data       (clr_data),
    .irq_en         (irq_en),
    .mode_susp      (mode_susp),
    .hub_configured (hub_configured),
    .hub_suspended  (hub_suspended),
    .status_q       (status_q),
    .irq_pull       (irq_pull)
);

// File: tb/irq_pin_ctrl_tb.sv
module irq_pin_ctrl_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] set_pulse = '0;
    logic         clr_we = 1'b0;
    logic [N-1:0] clr_data = '0;
    logic [N-1:0] irq_en = '0;
    logic         mode_susp = 1'b0;
    logic         hub_configured = 1'b0;
    logic         hub_suspended = 1'b0;
    logic         irq_pull;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_pin_ctrl #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .clr_we(clr_we),
        .clr_data(clr_data), .irq_en(irq_en), .mode_susp(mode_susp),
        .hub_configured(hub_configured), .hub_suspended(hub_suspended),
        .irq_pull(irq_pull)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_pull=%b expected %b", req, act, exp);
        end
    endtask

    task automatic pulse_set(logic [N-1:0] v);
        set_pulse = v;
        step();
        set_pulse = '0;
    endtask

    task automatic write_clr(logic [N-1:0] v);
        clr_we = 1'b1;
        clr_data = v;
        step();
        clr_we = 1'b0;
        clr_data = '0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            summary();
        end
    end

    initial begin
        step();
        step();
        // R9 / R1: pin released during and after reset
        check("R9 reset", irq_pull, 1'b0);
        rst_n = 1'b1;
        step();
        check("R1 released after reset", irq_pull, 1'b0);

        // R4, R3, R6: each bit alone, all enabled
        irq_en = '1;
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] b;
            b = '0;
            b[i] = 1'b1;
            pulse_set(b);
            check("R4 one edge after set, not yet pulled", irq_pull, 1'b0);
            step();
            check("R4 pulled two edges after set", irq_pull, 1'b1);
            write_clr(b);
            check("R6 still low one edge after clear", irq_pull, 1'b1);
            step();
            check("R6 released after clear", irq_pull, 1'b0);
        end

        // R3: clearing one bit leaves another pending
        pulse_set(8'h03);
        step();
        write_clr(8'h01);
        step();
        check("R3 untouched bit keeps pin low", irq_pull, 1'b1);
        write_clr(8'h02);
        step();
        check("R3 last bit cleared releases", irq_pull, 1'b0);

        // R2: set wins over simultaneous clear
        set_pulse = 8'h04;
        clr_we = 1'b1;
        clr_data = 8'h04;
        step();
        set_pulse = '0;
        clr_we = 1'b0;
        clr_data = '0;
        step();
        check("R2 set beats clear", irq_pull, 1'b1);
        write_clr('1);
        step();

        // R5: masked bit latches, later enable pulls in one edge
        irq_en = '0;
        pulse_set(8'h10);
        step();
        step();
        check("R5 masked bit does not pull", irq_pull, 1'b0);
        irq_en = 8'h10;
        step();
        check("R5 enable raises pull", irq_pull, 1'b1);
        irq_en = '0;
        step();
        check("R5 mask lowered releases", irq_pull, 1'b0);
        write_clr('1);

        // R4 / R5 exhaustive sweep over four sources
        for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 16; e++) begin
                logic [N-1:0] sv, ev;
                sv = '0;
                ev = '0;
                sv[3:0] = s[3:0];
                ev[3:0] = e[3:0];
                irq_en = ev;
                write_clr('1);
                pulse_set(sv);
                step();
                check("R5 sweep status and mask", irq_pull, ((s & e) != 0));
            end
        end
        write_clr('1);
        irq_en = '1;
        step();

        // R7: suspend mode, sweep hub state with status empty and full
        mode_susp = 1'b1;
        for (int st = 0; st < 2; st++) begin
            if (st == 1) begin
                pulse_set('1);
            end
            for (int h = 0; h < 4; h++) begin
                hub_configured = h[1];
                hub_suspended = h[0];
                step();
                check("R7 suspend level", irq_pull, !h[1] || h[0]);
            end
        end
        write_clr('1);

        // R8: mode switch on next edge, status kept
        hub_configured = 1'b1;
        hub_suspended = 1'b0;
        step();
        pulse_set(8'h20);
        step();
        check("R8 suspend mode ignores status", irq_pull, 1'b0);
        mode_susp = 1'b0;
        step();
        check("R8 general mode sees kept status", irq_pull, 1'b1);
        mode_susp = 1'b1;
        step();
        check("R8 back to suspend mode", irq_pull, 1'b0);
        mode_susp = 1'b0;
        step();
        check("R8 status still kept", irq_pull, 1'b1);

        // R9: reset mid-run clears status
        rst_n = 1'b0;
        step();
        check("R9 reset releases pin", irq_pull, 1'b0);
        rst_n = 1'b1;
        step();
        step();
        check("R9 status cleared by reset", irq_pull, 1'b0);

        done = 1'b1;
        summary();
    end
endmodule